// File: doc/BRIEF.md
# Prioritized Four-Channel DMA Transfer Sequencer

This block is the sequencing core of a small DMA controller. Each channel presents a pending request and three fixed values: a source address, a destination address and a size bit (halfword or word). The sequencer grants one unit transfer at a time. A unit is one read bus cycle followed by one write bus cycle. After every unit it scans the channels again, starting with channel 0. The run ends when no channel is pending. The bus cycles leave through a single master port that carries a sequential/nonsequential attribute. The block also raises an idle request for each bus cycle it spends without accessing memory.

The sequencer tracks one "ROM burst" flag and the channel that owns that burst. Any access to the ROM window sets the flag, and the bus path on the ROM side reads it. While the flag is set, accesses are marked sequential. When a different channel wins a unit, the flag is dropped before that unit's read. A run starts only when the bus is not locked by the CPU. Each run is framed by one idle cycle at the start and one at the end.

Top module: `dma_prio_engine`

## Requirements
- R1: When a unit is granted, the channel chosen is the lowest-numbered channel whose pending bit is 1.
- R2: The channels are scanned again from channel 0 after every unit. With channel 0 holding two units and channel 1 holding one, the order is 0, 0, 1.
- R3: A run starts only while `cpuBusLock` is 0. The first bus activity of a run is one cycle with `idleReq`=1. Next comes one cycle with no activity, then the first unit's read.
- R4: When a scan finds nothing pending, the run ends with one `idleReq` cycle. After that, `runActive`=0, `romAccess`=0 and `activeChan`=0.
- R5: If the granted channel is not the current `activeChan`, the ROM-burst flag is cleared before that unit's read is issued. `activeChan` then takes the granted channel.
- R6: An access whose aligned address has bit 27 set sets the ROM-burst flag (`romAccess`). Every read or write is issued with `busSeq`=1 (sequential) if the flag is set once its own address is counted, and with `busSeq`=0 otherwise.
- R7: A source or destination address below 0x0200_0000 is not put on the bus. That cycle raises `idleReq` instead, and `busValid` stays 0. A skipped read leaves the data latch unchanged.
- R8: A word unit (size bit 1) puts addresses on the bus with bits 1:0 cleared. A halfword unit (size bit 0) clears bit 0 only. `busIsWord` reflects the size.
- R9: A halfword read takes `busRdata[15:0]` and stores it in both halves of the 32-bit latch. Write data is the latch shifted right by 16 when aligned destination bit 1 is set, and unshifted otherwise.
- R10: The write slot of each unit, whether it is a bus write or an idle cycle, pulses `unitDone` for one cycle with `unitChan` set to the granted channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuBusLock | input | 1 | CPU holds the bus; a new run may not start |
| chanPending | input | 4 | Per-channel transfer request |
| chanWord | input | 4 | Per-channel size: 1 word, 0 halfword |
| chanSrc | input | 128 | Per-channel source address, channel n in bits 32n+31:32n |
| chanDst | input | 128 | Per-channel destination address, same packing |
| busRdata | input | 32 | Read data returned in the same cycle as the read |
| busValid | output | 1 | A bus access is issued this cycle |
| busWrite | output | 1 | 1 write, 0 read |
| busIsWord | output | 1 | 1 word access, 0 halfword |
| busSeq | output | 1 | 1 sequential, 0 nonsequential |
| busAddr | output | 32 | Aligned access address |
| busWdata | output | 32 | Write data |
| idleReq | output | 1 | Spend this cycle as an idle bus cycle |
| unitDone | output | 1 | A unit finishes this cycle |
| unitChan | output | 2 | Channel of the finishing unit |
| runActive | output | 1 | A DMA run is in progress |
| romAccess | output | 1 | ROM-burst flag for the ROM-side bus path |
| activeChan | output | 2 | Channel that owns the current burst |

## Verification
The assertions assume that every bus access finishes in a single cycle and that read data is valid in that same cycle. They also assume the channel addresses and size bits stay constant while a run is in progress, and that a pending bit drops only after the `unitDone` that used up that channel's last unit. The bench keeps inside these limits in three ways. It changes channel addresses only between runs. It counts down each channel's pending units at the falling edge after `unitDone`. Its memory model returns a combinational value computed from `busAddr`.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SCAN,
    ST_READ,
    ST_WRITE,
    ST_TAIL
  } seqState_t;

  // Strobes from the control FSM to the datapath, one hot per cycle.
  typedef struct packed {
    logic lead;
    logic scan;
    logic rd;
    logic wr;
    logic tail;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_prio_ctrl.sv
module dma_prio_ctrl
  import dma_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyPending,
  input  logic       cpuBusLock,
  output ctlStrobe_t strobe,
  output logic       runActive
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (anyPending && !cpuBusLock) stateD = ST_LEAD;
      ST_LEAD:  stateD = ST_SCAN;
      ST_SCAN:  stateD = anyPending ? ST_READ : ST_TAIL;
      ST_READ:  stateD = ST_WRITE;
      ST_WRITE: stateD = ST_SCAN;
      ST_TAIL:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.lead = (stateQ == ST_LEAD);
    strobe.scan = (stateQ == ST_SCAN);
    strobe.rd   = (stateQ == ST_READ);
    strobe.wr   = (stateQ == ST_WRITE);
    strobe.tail = (stateQ == ST_TAIL);
  end

  assign runActive = (stateQ != ST_IDLE);

endmodule

// File: rtl/dma_prio_datapath.sv
module dma_prio_datapath
  import dma_prio_pkg::*;
#(
  parameter int              NUM_CHAN  = 4,
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              ROM_BIT   = 27,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 32'h0200_0000,
  localparam int             CW        = $clog2(NUM_CHAN),
  localparam int             HALF_W    = DATA_W / 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [NUM_CHAN-1:0]        chanPending,
  input  logic [NUM_CHAN-1:0]        chanWord,
  input  logic [NUM_CHAN*ADDR_W-1:0] chanSrc,
  input  logic [NUM_CHAN*ADDR_W-1:0] chanDst,
  input  logic [DATA_W-1:0]          busRdata,
  output logic                       busValid,
  output logic                       busWrite,
  output logic                       busIsWord,
  output logic                       busSeq,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          busWdata,
  output logic                       idleReq,
  output logic                       unitDone,
  output logic [CW-1:0]              unitChan,
  output logic                       romAccess,
  output logic [CW-1:0]              activeChan
);

  logic [ADDR_W-1:0] srcArr [NUM_CHAN];
  logic [ADDR_W-1:0] dstArr [NUM_CHAN];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gSlice
    assign srcArr[g] = chanSrc[g*ADDR_W +: ADDR_W];
    assign dstArr[g] = chanDst[g*ADDR_W +: ADDR_W];
  end

  // Fixed priority: lowest index wins.
  logic [CW-1:0] pickIdx;
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (chanPending[i]) pickIdx = CW'(i);
    end
  end

  logic [CW-1:0]     grantQ;
  logic [CW-1:0]     activeQ;
  logic              romBurstQ;
  logic [DATA_W-1:0] latchQ;

  logic              isWord;
  logic [ADDR_W-1:0] alignMask;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic              srcOk, dstOk;
  logic              romBase;
  logic              rdRomFlag, wrRomFlag;

  always_comb begin
    isWord    = chanWord[grantQ];
    alignMask = isWord ? ~ADDR_W'(3) : ~ADDR_W'(1);
    srcAddr   = srcArr[grantQ] & alignMask;
    dstAddr   = dstArr[grantQ] & alignMask;
    srcOk     = (srcAddr >= LOW_LIMIT);
    dstOk     = (dstAddr >= LOW_LIMIT);
    // A new owner starts its burst from a cleared flag.
    romBase   = (grantQ != activeQ) ? 1'b0 : romBurstQ;
    rdRomFlag = romBase | (srcOk & srcAddr[ROM_BIT]);
    wrRomFlag = romBurstQ | (dstOk & dstAddr[ROM_BIT]);
  end

  always_comb begin
    busValid  = (strobe.rd & srcOk) | (strobe.wr & dstOk);
    busWrite  = strobe.wr;
    busIsWord = busValid & isWord;
    busAddr   = strobe.rd ? srcAddr : dstAddr;
    busSeq    = busValid & (strobe.rd ? rdRomFlag : wrRomFlag);
    busWdata  = strobe.wr ? (dstAddr[1] ? (latchQ >> HALF_W) : latchQ) : '0;
    idleReq   = strobe.lead | strobe.tail | (strobe.rd & ~srcOk) | (strobe.wr & ~dstOk);
    unitDone  = strobe.wr;
    unitChan  = grantQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ    <= '0;
      activeQ   <= '0;
      romBurstQ <= 1'b0;
      latchQ    <= '0;
    end else begin
      if (strobe.scan) grantQ <= pickIdx;
      if (strobe.rd) begin
        activeQ   <= grantQ;
        romBurstQ <= rdRomFlag;
        if (srcOk) latchQ <= isWord ? busRdata : {busRdata[HALF_W-1:0], busRdata[HALF_W-1:0]};
      end
      if (strobe.wr) romBurstQ <= wrRomFlag;
      if (strobe.tail) begin
        romBurstQ <= 1'b0;
        activeQ   <= '0;
      end
    end
  end

  assign romAccess  = romBurstQ;
  assign activeChan = activeQ;

endmodule

// File: rtl/dma_prio_engine.sv
module dma_prio_engine
  import dma_prio_pkg::*;
#(
  parameter int                NUM_CHAN  = 4,
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                ROM_BIT   = 27,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 32'h0200_0000,
  localparam int               CW        = $clog2(NUM_CHAN)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cpuBusLock,
  input  logic [NUM_CHAN-1:0]        chanPending,
  input  logic [NUM_CHAN-1:0]        chanWord,
  input  logic [NUM_CHAN*ADDR_W-1:0] chanSrc,
  input  logic [NUM_CHAN*ADDR_W-1:0] chanDst,
  input  logic [DATA_W-1:0]          busRdata,
  output logic                       busValid,
  output logic                       busWrite,
  output logic                       busIsWord,
  output logic                       busSeq,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          busWdata,
  output logic                       idleReq,
  output logic                       unitDone,
  output logic [CW-1:0]              unitChan,
  output logic                       runActive,
  output logic                       romAccess,
  output logic [CW-1:0]              activeChan
);

  ctlStrobe_t strobe;

  dma_prio_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .anyPending (|chanPending),
    .cpuBusLock (cpuBusLock),
    .strobe     (strobe),
    .runActive  (runActive)
  );

  dma_prio_datapath #(
    .NUM_CHAN  (NUM_CHAN),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ROM_BIT   (ROM_BIT),
    .LOW_LIMIT (LOW_LIMIT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chanPending (chanPending),
    .chanWord    (chanWord),
    .chanSrc     (chanSrc),
    .chanDst     (chanDst),
    .busRdata    (busRdata),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busIsWord   (busIsWord),
    .busSeq      (busSeq),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .idleReq     (idleReq),
    .unitDone    (unitDone),
    .unitChan    (unitChan),
    .romAccess   (romAccess),
    .activeChan  (activeChan)
  );

endmodule

// File: rtl/dma_prio_checker.sv
module dma_prio_checker #(
  parameter int                ADDR_W    = 32,
  parameter int                ROM_BIT   = 27,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 32'h0200_0000,
  parameter int                CW        = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuBusLock,
  input logic              busValid,
  input logic              busWrite,
  input logic              busIsWord,
  input logic              busSeq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              idleReq,
  input logic              unitDone,
  input logic              runActive,
  input logic              romAccess,
  input logic [CW-1:0]     activeChan
);

  AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!runActive && cpuBusLock) |=> !runActive);                          // R3

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runActive) |-> (!romAccess && activeChan == '0));              // R4

  AST_ROM_IS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr[ROM_BIT]) |-> busSeq);                          // R6

  AST_ROM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr[ROM_BIT] && runActive) |=> (romAccess || !runActive)); // R6

  AST_LOW_NOT_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr >= LOW_LIMIT));                                // R7

  AST_IDLE_XOR_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && idleReq));                                             // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busIsWord) |-> (busAddr[1:0] == 2'b00));                // R8

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[0] == 1'b0));                                  // R8

  AST_WRITE_ENDS_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> unitDone);                                // R10

  AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    unitDone |-> (runActive && !$past(unitDone)));                       // R10

endmodule

bind dma_prio_engine dma_prio_checker #(
  .ADDR_W    (ADDR_W),
  .ROM_BIT   (ROM_BIT),
  .LOW_LIMIT (LOW_LIMIT),
  .CW        (CW)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cpuBusLock (cpuBusLock),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busIsWord  (busIsWord),
  .busSeq     (busSeq),
  .busAddr    (busAddr),
  .idleReq    (idleReq),
  .unitDone   (unitDone),
  .runActive  (runActive),
  .romAccess  (romAccess),
  .activeChan (activeChan)
);

// File: tb/dma_prio_engine_tb.sv
module dma_prio_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuBusLock = 1'b0;
  logic [3:0]  chanPending = '0;
  logic [3:0]  chanWord = '0;
  logic [127:0] chanSrc = '0;
  logic [127:0] chanDst = '0;
  logic [31:0] busRdata;
  logic        busValid, busWrite, busIsWord, busSeq;
  logic [31:0] busAddr, busWdata;
  logic        idleReq, unitDone, runActive, romAccess;
  logic [1:0]  unitChan, activeChan;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[31:16] ^ a[15:0] ^ 16'h1234};
  endfunction

  assign busRdata = memWord(busAddr);

  dma_prio_engine dut_i (
    .clk(clk), .rstN(rstN), .cpuBusLock(cpuBusLock),
    .chanPending(chanPending), .chanWord(chanWord),
    .chanSrc(chanSrc), .chanDst(chanDst), .busRdata(busRdata),
    .busValid(busValid), .busWrite(busWrite), .busIsWord(busIsWord),
    .busSeq(busSeq), .busAddr(busAddr), .busWdata(busWdata),
    .idleReq(idleReq), .unitDone(unitDone), .unitChan(unitChan),
    .runActive(runActive), .romAccess(romAccess), .activeChan(activeChan)
  );

  typedef struct {
    int          kind;   // 0 idle, 1 read, 2 write
    logic [31:0] addr;
    logic        seq;
    logic        word;
    logic [31:0] wdata;
    logic        done;
    int          chan;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          cnt [NCH];
  logic [31:0] src [NCH];
  logic [31:0] dst [NCH];
  logic        wrd [NCH];

  // Independent reference state
  logic        mRf = 0;
  int          mAct = 0;
  logic [31:0] mLatch = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void pushIdle(input logic done, input int ch, input string tag);
    expItem_t it;
    it.kind = 0; it.addr = '0; it.seq = 0; it.word = 0; it.wdata = '0;
    it.done = done; it.chan = ch; it.tag = tag;
    expQ.push_back(it);
  endfunction

  // Driver: push the expected bus trace of a whole run from the counts.
  function automatic void predictRun(input string tag);
    int left [NCH];
    for (int i = 0; i < NCH; i++) left[i] = cnt[i];
    pushIdle(0, 0, tag);                               // R3 lead idle
    forever begin
      int ch = -1;
      logic [31:0] m, s, d;
      for (int i = NCH - 1; i >= 0; i--) if (left[i] > 0) ch = i;  // R1 R2
      if (ch < 0) break;
      left[ch]--;
      if (ch != mAct) begin mRf = 0; mAct = ch; end    // R5
      m = wrd[ch] ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;      // R8
      s = src[ch] & m;
      d = dst[ch] & m;
      if (s >= 32'h0200_0000) begin
        expItem_t it;
        mRf = mRf | s[27];                              // R6
        mLatch = wrd[ch] ? memWord(s) : {memWord(s)[15:0], memWord(s)[15:0]}; // R9
        it.kind = 1; it.addr = s; it.seq = mRf; it.word = wrd[ch];
        it.wdata = '0; it.done = 0; it.chan = ch; it.tag = tag;
        expQ.push_back(it);
      end else pushIdle(0, ch, tag);                    // R7
      if (d >= 32'h0200_0000) begin
        expItem_t it;
        mRf = mRf | d[27];
        it.kind = 2; it.addr = d; it.seq = mRf; it.word = wrd[ch];
        it.wdata = d[1] ? (mLatch >> 16) : mLatch;      // R9
        it.done = 1; it.chan = ch; it.tag = tag;        // R10
        expQ.push_back(it);
      end else pushIdle(1, ch, tag);                    // R7 R10
    end
    pushIdle(0, 0, tag);                                // R4 tail idle
    mRf = 0; mAct = 0;
  endfunction

  // Monitor: compare every bus or idle cycle against the queue.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (busValid || idleReq)) begin
        int k;
        k = idleReq ? 0 : (busWrite ? 2 : 1);
        if (expQ.size() == 0) begin
          check(0, "R3", "unexpected bus cycle kind", k, 32'hFFFF_FFFF);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(k == e.kind, e.tag, "cycle kind", k, e.kind);
          if (k == e.kind && k != 0) begin
            check(busAddr == e.addr, e.tag, "address", busAddr, e.addr);
            check(busSeq == e.seq, e.tag, "seq attr", busSeq, e.seq);
            check(busIsWord == e.word, e.tag, "size", busIsWord, e.word);
          end
          if (k == e.kind && k == 2)
            check(busWdata == e.wdata, e.tag, "write data", busWdata, e.wdata);
          if (k == e.kind && k != 1) begin
            check(unitDone == e.done, e.tag, "unitDone", unitDone, e.done);
            if (e.done) check(unitChan == 2'(e.chan), e.tag, "unitChan", unitChan, e.chan);
          end
        end
      end
    end
  end

  // Pending bookkeeping, driven away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (unitDone) cnt[unitChan]--;
      for (int i = 0; i < NCH; i++) chanPending[i] = (cnt[i] > 0);
    end
  end

  task automatic setChan(input int i, input logic [31:0] s, input logic [31:0] d,
                         input logic w, input int n);
    src[i] = s; dst[i] = d; wrd[i] = w; cnt[i] = n;
    chanSrc[i*32 +: 32] = s;
    chanDst[i*32 +: 32] = d;
    chanWord[i] = w;
  endtask

  task automatic clearChans();
    for (int i = 0; i < NCH; i++) setChan(i, 32'h0300_0000, 32'h0300_0000, 1'b0, 0);
  endtask

  task automatic waitRunEnd(input string tag);
    int t = 0;
    while (!runActive && t < 50) begin @(negedge clk); t++; end
    t = 0;
    while (runActive && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    check(expQ.size() == 0, tag, "trace items left", expQ.size(), 0);
    check(runActive == 0, "R4", "runActive after run", runActive, 0);
    check(romAccess == 0, "R4", "romAccess after run", romAccess, 0);
    check(activeChan == 0, "R4", "activeChan after run", activeChan, 0);
    expQ.delete();
  endtask

  // Runs one scenario: set channels before this call at a falling edge.
  task automatic runScenario(input string tag);
    predictRun(tag);
    waitRunEnd(tag);
    clearChans();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(runActive == 0 && busValid == 0 && idleReq == 0, "R4", "reset quiet",
          {runActive, busValid, idleReq}, 0);
    check(romAccess == 0 && activeChan == 0, "R4", "reset flags",
          {romAccess, activeChan}, 0);

    // R1 R2: rescan from channel 0 after each unit -> 0,0,1,3
    clearChans();
    setChan(0, 32'h0300_0100, 32'h0200_0200, 1'b1, 2);
    setChan(1, 32'h0300_0044, 32'h0200_0046, 1'b0, 1);
    setChan(3, 32'h0200_0010, 32'h0300_0018, 1'b1, 1);
    runScenario("R2");

    // R6: ROM source marks burst sequential, read and write
    setChan(2, 32'h0800_0010, 32'h0300_0006, 1'b0, 2);
    runScenario("R6");
    check(romAccess == 0, "R6", "flag dropped after ROM run", romAccess, 0);

    // R5: ROM on channel 1, then channel 3 (RAM) must start nonsequential
    setChan(1, 32'h0900_0020, 32'h0200_0300, 1'b1, 1);
    setChan(3, 32'h0200_0400, 32'h0300_0400, 1'b1, 1);
    runScenario("R5");

    // R7: low source keeps latch; low destination on another channel
    setChan(0, 32'h0300_0500, 32'h0200_0500, 1'b1, 1);
    setChan(1, 32'h0000_1000, 32'h0200_0600, 1'b1, 1);
    setChan(2, 32'h0300_0700, 32'h0000_0100, 1'b0, 1);
    runScenario("R7");

    // R8 R9: unaligned addresses, halfword duplication and lane shift
    setChan(0, 32'h0200_0803, 32'h0300_080A, 1'b1, 1);
    setChan(1, 32'h0300_0907, 32'h0200_0903, 1'b0, 1);
    setChan(2, 32'h0300_0A05, 32'h0200_0A01, 1'b0, 1);
    runScenario("R8");

    // R3: no start while the CPU holds the bus
    cpuBusLock = 1'b1;
    setChan(2, 32'h0300_0B00, 32'h0200_0B00, 1'b1, 1);
    repeat (6) @(negedge clk);
    check(runActive == 0, "R3", "no run while locked", runActive, 0);
    check(busValid == 0 && idleReq == 0, "R3", "bus quiet while locked",
          {busValid, idleReq}, 0);
    predictRun("R3");
    cpuBusLock = 1'b0;
    waitRunEnd("R3");
    clearChans();
    @(negedge clk);

    // R10 + R1 mixed: all four channels, ROM destination in middle
    setChan(0, 32'h0300_0C00, 32'h0200_0C00, 1'b0, 1);
    setChan(1, 32'h0300_0D00, 32'h0A00_0D02, 1'b0, 2);
    setChan(2, 32'h0200_0E00, 32'h0300_0E00, 1'b1, 1);
    setChan(3, 32'h0300_0F00, 32'h0200_0F00, 1'b1, 1);
    runScenario("R10");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule